// File: doc/BRIEF.md
# Three-wide register renamer with committed map

This block sits between decode and scheduling in an out-of-order core. Each cycle it accepts a group of up to three micro-ops. It gives every destination a fresh physical register and every micro-op a slot in the reorder sequence. It also translates each source operand to the physical register that holds its newest value. Register values themselves live elsewhere. The block only handles names and the order in which they were handed out.

Two alias tables are kept. The speculative table follows every accepted rename. The committed table changes only when the oldest micro-ops retire. At retirement nothing is copied. The committed table is simply pointed at the retiring micro-op's register, and the register it named before goes back to the pool. A flush throws away all work that has not retired. The speculative table is reloaded from the committed one, every uncommitted physical register becomes free again, and slot allocation restarts at the oldest live position.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register a maps to physical register a in both tables, registers NUM_ARCH and above are free, and the first accepted micro-op gets slot 0.
- R2: In an accepted group, each valid slot with a destination, taken in slot order, receives the lowest-numbered free physical register not already taken by an earlier slot. Valid slots receive consecutive reorder slot indices from the tail, skipping invalid slots and wrapping modulo ROB_DEPTH, which must be a power of two.
- R3: A source operand reads the speculative table, unless an older valid slot in the same group writes the same architectural register. In that case it reads the physical register of the youngest such slot.
- R4: After an accepted group, the speculative table holds the new mapping for every written register. When two slots write the same register, the younger one wins.
- R5: `ren_ready_o` is low, and the whole group is dropped with no change of state, when the group needs more physical registers than are free or more slots than the reorder buffer has empty.
- R6: `ret_cnt_i` retires that many of the oldest entries, clamped to the occupancy. Each retiring destination points the committed table at its physical register, and the register named there before becomes allocatable from the next cycle.
- R7: A retiring entry without a destination changes neither table nor the free pool.
- R8: While `flush_i` is high, `ren_ready_o` is low and any group on the inputs is dropped. The next cycle the speculative table equals the committed table, including retirements made in the flush cycle. All registers not named by the committed table are free, and the reorder buffer is empty with its next slot at the retire position.
- R9: A physical register is never handed out while the speculative table still names it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all unretired work |
| ren_valid_i | input | GROUP | Slot holds a micro-op |
| ren_has_dst_i | input | GROUP | Slot writes a destination |
| ren_dst_i | input | GROUP x log2(NUM_ARCH) | Architectural destination per slot |
| ren_src_a_i | input | GROUP x log2(NUM_ARCH) | First architectural source per slot |
| ren_src_b_i | input | GROUP x log2(NUM_ARCH) | Second architectural source per slot |
| ret_cnt_i | input | log2(GROUP+1) | Number of oldest entries to retire |
| ren_ready_o | output | 1 | Group on the inputs is accepted this cycle |
| ren_pdst_o | output | GROUP x log2(NUM_PHYS) | Physical destination per slot |
| ren_psrc_a_o | output | GROUP x log2(NUM_PHYS) | Physical first source per slot |
| ren_psrc_b_o | output | GROUP x log2(NUM_PHYS) | Physical second source per slot |
| ren_rob_idx_o | output | GROUP x log2(ROB_DEPTH) | Reorder slot index per slot |

## Verification
The bench targets several corner cases, and each has a visible failure:

- **Same-group forwarding.** A source that should forward from an older slot would show the stale table entry.
- **Duplicate destinations in one group.** If both slots write the same register and the older one wins, later groups read the wrong register.
- **Partial groups with invalid slots.** A design that counts invalid slots when numbering would leave holes in the slot indices.
- **Exhaustion.** The bench drains the free pool and the reorder buffer separately. A design that stalls on only one resource, or accepts part of a group, hands out a register or slot twice.
- **Retirement.** Retiring with an empty buffer must not release anything. A retirement that frees the new register instead of the old one shows up at once in later allocation order.
- **Flush in the same cycle as a retire.** This checks that the reload uses the updated committed map.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned DEF_ARCH  = 16;
  localparam int unsigned DEF_PHYS  = 128;
  localparam int unsigned DEF_ROB   = 64;
  localparam int unsigned DEF_GROUP = 3;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned NUM_PHYS = 128,
  parameter int unsigned NUM_ARCH = 16,
  parameter int unsigned GROUP    = 3,
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned NW = $clog2(NUM_PHYS + 1),
  localparam int unsigned GW = $clog2(GROUP + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic [GW-1:0]                 alloc_n_i,
  input  logic [NUM_PHYS-1:0]           release_i,
  input  logic [NUM_PHYS-1:0]           keep_i,
  output logic [GROUP-1:0][PW-1:0]      pick_o,
  output logic [NW-1:0]                 free_cnt_o
);
  logic [NUM_PHYS-1:0] free_q, free_d, avail, take;
  logic [GROUP-1:0][NUM_PHYS-1:0] pick_oh;

  // lowest-first picks, one per group slot
  always_comb begin
    avail = free_q;
    take  = '0;
    for (int k = 0; k < int'(GROUP); k++) begin
      pick_oh[k] = '0;
      pick_o[k]  = '0;
      for (int p = int'(NUM_PHYS) - 1; p >= 0; p--) begin
        if (avail[p]) begin
          pick_oh[k]    = '0;
          pick_oh[k][p] = 1'b1;
          pick_o[k]     = PW'(p);
        end
      end
      avail = avail & ~pick_oh[k];
      if (k < int'(alloc_n_i)) take = take | pick_oh[k];
    end
  end

  always_comb begin
    free_cnt_o = '0;
    for (int p = 0; p < int'(NUM_PHYS); p++) free_cnt_o = free_cnt_o + NW'(free_q[p]);
  end

  // flush rebuilds the pool from the committed map
  assign free_d = flush_i ? ~keep_i : ((free_q & ~take) | release_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < int'(NUM_PHYS); p++) free_q[p] <= (p >= int'(NUM_ARCH));
    end else begin
      free_q <= free_d;
    end
  end

  // R6
  release_not_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i & free_q) == '0);

  // R2
  taken_leaves_pool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && take != '0) |=> (($past(take) & free_q) == '0));
endmodule

// File: rtl/rn_rob.sv
module rn_rob #(
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned GROUP    = 3,
  parameter int unsigned NUM_ARCH = 16,
  parameter int unsigned NUM_PHYS = 128,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = IW + 1,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned GW = $clog2(GROUP + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     push_en_i,
  input  logic [GROUP-1:0]         push_valid_i,
  input  logic [GROUP-1:0]         push_has_dst_i,
  input  logic [GROUP-1:0][AW-1:0] push_arch_i,
  input  logic [GROUP-1:0][PW-1:0] push_preg_i,
  input  logic [GW-1:0]            ret_req_i,
  output logic [IW-1:0]            tail_o,
  output logic [CW-1:0]            space_o,
  output logic [GROUP-1:0]         ret_valid_o,
  output logic [GROUP-1:0]         ret_has_dst_o,
  output logic [GROUP-1:0][AW-1:0] ret_arch_o,
  output logic [GROUP-1:0][PW-1:0] ret_preg_o
);
  logic          has_q  [DEPTH];
  logic [AW-1:0] arch_q [DEPTH];
  logic [PW-1:0] preg_q [DEPTH];

  logic [IW-1:0] head_q, tail_q, head_d;
  logic [CW-1:0] count_q;
  logic [GW-1:0] n_push, n_ret, req_c;
  logic [GROUP-1:0]         wr_en;
  logic [GROUP-1:0][IW-1:0] wr_idx;

  always_comb begin
    n_push = '0;
    for (int i = 0; i < int'(GROUP); i++) begin
      wr_idx[i] = tail_q + IW'(n_push);
      wr_en[i]  = push_en_i & push_valid_i[i];
      if (wr_en[i]) n_push = n_push + GW'(1);
    end
  end

  always_comb begin
    req_c = (int'(ret_req_i) > int'(GROUP)) ? GW'(GROUP) : ret_req_i;
    n_ret = (CW'(req_c) > count_q) ? GW'(count_q) : req_c;
    for (int k = 0; k < int'(GROUP); k++) begin
      ret_valid_o[k]   = (k < int'(n_ret));
      ret_has_dst_o[k] = has_q[head_q + IW'(k)];
      ret_arch_o[k]    = arch_q[head_q + IW'(k)];
      ret_preg_o[k]    = preg_q[head_q + IW'(k)];
    end
  end

  assign head_d  = head_q + IW'(n_ret);
  assign tail_o  = tail_q;
  assign space_o = CW'(DEPTH) - count_q;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < int'(GROUP); i++) begin
      if (wr_en[i]) begin
        has_q[wr_idx[i]]  <= push_has_dst_i[i];
        arch_q[wr_idx[i]] <= push_arch_i[i];
        preg_q[wr_idx[i]] <= push_preg_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q <= head_d;
      if (flush_i) begin
        tail_q  <= head_d;
        count_q <= '0;
      end else begin
        tail_q  <= tail_q + IW'(n_push);
        count_q <= count_q - CW'(n_ret) + CW'(n_push);
      end
    end
  end

  // R5
  rob_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= int'(DEPTH));

  // R5
  push_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_en_i |-> (int'(count_q) + int'(n_push) <= int'(DEPTH)));

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0 && tail_q == head_q));
endmodule

// File: rtl/rn_retire_map.sv
module rn_retire_map #(
  parameter int unsigned NUM_ARCH = 16,
  parameter int unsigned NUM_PHYS = 128,
  parameter int unsigned GROUP    = 3,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [GROUP-1:0]            ret_valid_i,
  input  logic [GROUP-1:0]            ret_has_dst_i,
  input  logic [GROUP-1:0][AW-1:0]    ret_arch_i,
  input  logic [GROUP-1:0][PW-1:0]    ret_preg_i,
  output logic [NUM_ARCH-1:0][PW-1:0] next_map_o,
  output logic [NUM_PHYS-1:0]         release_o,
  output logic [NUM_PHYS-1:0]         keep_o
);
  logic [NUM_ARCH-1:0][PW-1:0] map_q, map_d;

  // in-order walk: a later retire to the same register frees the earlier one
  always_comb begin
    map_d     = map_q;
    release_o = '0;
    for (int k = 0; k < int'(GROUP); k++) begin
      if (ret_valid_i[k] && ret_has_dst_i[k]) begin
        release_o[map_d[ret_arch_i[k]]] = 1'b1;
        map_d[ret_arch_i[k]]            = ret_preg_i[k];
      end
    end
  end

  always_comb begin
    keep_o = '0;
    for (int a = 0; a < int'(NUM_ARCH); a++) keep_o[map_d[a]] = 1'b1;
  end

  assign next_map_o = map_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < int'(NUM_ARCH); a++) map_q[a] <= PW'(a);
    end else begin
      map_q <= map_d;
    end
  end

  // R6
  freed_not_committed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_o & keep_o) == '0);
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer
  import rn_pkg::*;
#(
  parameter int unsigned NUM_ARCH  = DEF_ARCH,
  parameter int unsigned NUM_PHYS  = DEF_PHYS,
  parameter int unsigned ROB_DEPTH = DEF_ROB,
  parameter int unsigned GROUP     = DEF_GROUP,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned IW = $clog2(ROB_DEPTH),
  localparam int unsigned CW = IW + 1,
  localparam int unsigned NW = $clog2(NUM_PHYS + 1),
  localparam int unsigned GW = $clog2(GROUP + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic [GROUP-1:0]         ren_valid_i,
  input  logic [GROUP-1:0]         ren_has_dst_i,
  input  logic [GROUP-1:0][AW-1:0] ren_dst_i,
  input  logic [GROUP-1:0][AW-1:0] ren_src_a_i,
  input  logic [GROUP-1:0][AW-1:0] ren_src_b_i,
  input  logic [GW-1:0]            ret_cnt_i,
  output logic                     ren_ready_o,
  output logic [GROUP-1:0][PW-1:0] ren_pdst_o,
  output logic [GROUP-1:0][PW-1:0] ren_psrc_a_o,
  output logic [GROUP-1:0][PW-1:0] ren_psrc_b_o,
  output logic [GROUP-1:0][IW-1:0] ren_rob_idx_o
);
  logic [NUM_ARCH-1:0][PW-1:0] fmap_q, fmap_d, cmap_next;
  logic [GROUP-1:0][PW-1:0]    pick;
  logic [GROUP-1:0][GW-1:0]    d_before, v_before;
  logic [GW-1:0]               d_cnt, v_cnt;
  logic [NW-1:0]               free_cnt;
  logic [CW-1:0]               rob_space;
  logic [IW-1:0]               rob_tail;
  logic [NUM_PHYS-1:0]         release_mask, keep_mask;
  logic                        accept;

  logic [GROUP-1:0]         ret_valid, ret_has_dst;
  logic [GROUP-1:0][AW-1:0] ret_arch;
  logic [GROUP-1:0][PW-1:0] ret_preg;

  always_comb begin
    d_cnt = '0;
    v_cnt = '0;
    for (int i = 0; i < int'(GROUP); i++) begin
      d_before[i] = d_cnt;
      v_before[i] = v_cnt;
      if (ren_valid_i[i]) begin
        v_cnt = v_cnt + GW'(1);
        if (ren_has_dst_i[i]) d_cnt = d_cnt + GW'(1);
      end
    end
  end

  // all-or-nothing: a group that does not fit entirely is held
  assign ren_ready_o = !flush_i && (NW'(d_cnt) <= free_cnt) && (CW'(v_cnt) <= rob_space);
  assign accept      = ren_ready_o && (ren_valid_i != '0);

  always_comb begin
    for (int i = 0; i < int'(GROUP); i++) begin
      ren_pdst_o[i]    = pick[d_before[i]];
      ren_rob_idx_o[i] = rob_tail + IW'(v_before[i]);
    end
  end

  // intra-group forwarding; the youngest older writer wins
  always_comb begin
    for (int i = 0; i < int'(GROUP); i++) begin
      ren_psrc_a_o[i] = fmap_q[ren_src_a_i[i]];
      ren_psrc_b_o[i] = fmap_q[ren_src_b_i[i]];
      for (int j = 0; j < i; j++) begin
        if (ren_valid_i[j] && ren_has_dst_i[j]) begin
          if (ren_dst_i[j] == ren_src_a_i[i]) ren_psrc_a_o[i] = ren_pdst_o[j];
          if (ren_dst_i[j] == ren_src_b_i[i]) ren_psrc_b_o[i] = ren_pdst_o[j];
        end
      end
    end
  end

  always_comb begin
    fmap_d = fmap_q;
    if (flush_i) begin
      fmap_d = cmap_next;
    end else if (accept) begin
      for (int i = 0; i < int'(GROUP); i++) begin
        if (ren_valid_i[i] && ren_has_dst_i[i]) fmap_d[ren_dst_i[i]] = ren_pdst_o[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < int'(NUM_ARCH); a++) fmap_q[a] <= PW'(a);
    end else begin
      fmap_q <= fmap_d;
    end
  end

  rn_free_list #(
    .NUM_PHYS (NUM_PHYS),
    .NUM_ARCH (NUM_ARCH),
    .GROUP    (GROUP)
  ) i_free_list (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .alloc_n_i  (accept ? d_cnt : '0),
    .release_i  (release_mask),
    .keep_i     (keep_mask),
    .pick_o     (pick),
    .free_cnt_o (free_cnt)
  );

  rn_rob #(
    .DEPTH    (ROB_DEPTH),
    .GROUP    (GROUP),
    .NUM_ARCH (NUM_ARCH),
    .NUM_PHYS (NUM_PHYS)
  ) i_rob (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (flush_i),
    .push_en_i      (accept),
    .push_valid_i   (ren_valid_i),
    .push_has_dst_i (ren_has_dst_i),
    .push_arch_i    (ren_dst_i),
    .push_preg_i    (ren_pdst_o),
    .ret_req_i      (ret_cnt_i),
    .tail_o         (rob_tail),
    .space_o        (rob_space),
    .ret_valid_o    (ret_valid),
    .ret_has_dst_o  (ret_has_dst),
    .ret_arch_o     (ret_arch),
    .ret_preg_o     (ret_preg)
  );

  rn_retire_map #(
    .NUM_ARCH (NUM_ARCH),
    .NUM_PHYS (NUM_PHYS),
    .GROUP    (GROUP)
  ) i_retire_map (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ret_valid_i   (ret_valid),
    .ret_has_dst_i (ret_has_dst),
    .ret_arch_i    (ret_arch),
    .ret_preg_i    (ret_preg),
    .next_map_o    (cmap_next),
    .release_o     (release_mask),
    .keep_o        (keep_mask)
  );

  logic map_clash;
  always_comb begin
    map_clash = 1'b0;
    for (int i = 0; i < int'(GROUP); i++) begin
      if (ren_valid_i[i] && ren_has_dst_i[i]) begin
        for (int a = 0; a < int'(NUM_ARCH); a++) begin
          if (fmap_q[a] == ren_pdst_o[i]) map_clash = 1'b1;
        end
      end
    end
  end

  // R9
  alloc_unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> !map_clash);
endmodule

// File: tb/test_reg_renamer.sv
`timescale 1ns/1ps
module test_reg_renamer;
  localparam int NA = 16, NP = 40, RD = 32, W = 3;
  localparam int AW = 4, PW = 6, IW = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0, flush_i = 1'b0;
  logic [W-1:0] ren_valid_i = '0, ren_has_dst_i = '0;
  logic [W-1:0][AW-1:0] ren_dst_i = '0, ren_src_a_i = '0, ren_src_b_i = '0;
  logic [1:0] ret_cnt_i = '0;
  logic ren_ready_o;
  logic [W-1:0][PW-1:0] ren_pdst_o, ren_psrc_a_o, ren_psrc_b_o;
  logic [W-1:0][IW-1:0] ren_rob_idx_o;

  always #2 clk_i = ~clk_i;

  reg_renamer #(.NUM_ARCH(NA), .NUM_PHYS(NP), .ROB_DEPTH(RD), .GROUP(W)) i_reg_renamer (
    .clk_i, .rst_ni, .flush_i, .ren_valid_i, .ren_has_dst_i, .ren_dst_i,
    .ren_src_a_i, .ren_src_b_i, .ret_cnt_i, .ren_ready_o, .ren_pdst_o,
    .ren_psrc_a_o, .ren_psrc_b_o, .ren_rob_idx_o
  );

  typedef struct { bit has; int arch; int preg; } rob_t;
  typedef struct { string tag; bit rdy; bit [2:0] v; bit [2:0] h;
                   int pd[3]; int pa[3]; int pb[3]; int ri[3]; } exp_t;

  int fmap[NA], rmap[NA];
  bit freev[NP];
  rob_t robq[$];
  exp_t expq[$];
  exp_t mon_e;
  int tail_m = 0, head_m = 0;
  int checks = 0, errors = 0;

  function automatic logic [11:0] pk(int x0, int x1, int x2);
    return {x2[3:0], x1[3:0], x0[3:0]};
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the predicted result
  task automatic step(string tag, logic [2:0] v, logic [2:0] h, logic [11:0] d,
                      logic [11:0] a, logic [11:0] b, int rc, bit fl);
    exp_t e;
    int fl_list[$];
    int nv, nd, occ, vb, db, n;
    rob_t r;
    @(posedge clk_i); #1;
    ren_valid_i = v; ren_has_dst_i = h; ren_dst_i = d;
    ren_src_a_i = a; ren_src_b_i = b; ret_cnt_i = 2'(rc); flush_i = fl;
    nv = 0; nd = 0;
    for (int i = 0; i < W; i++) if (v[i]) begin nv++; if (h[i]) nd++; end
    for (int p = 0; p < NP; p++) if (freev[p]) fl_list.push_back(p);
    occ = robq.size();
    e.tag = tag; e.v = v; e.h = h;
    e.rdy = !fl && (nd <= fl_list.size()) && (nv <= RD - occ);
    vb = 0; db = 0;
    for (int i = 0; i < W; i++) begin
      e.pd[i] = 0; e.pa[i] = 0; e.pb[i] = 0; e.ri[i] = 0;
      if (v[i]) begin
        e.ri[i] = (tail_m + vb) % RD; vb++;
        if (h[i] && db < fl_list.size()) e.pd[i] = fl_list[db];
        e.pa[i] = fmap[a[i*4 +: 4]];
        e.pb[i] = fmap[b[i*4 +: 4]];
        for (int j = 0; j < i; j++) if (v[j] && h[j]) begin
          if (d[j*4 +: 4] == a[i*4 +: 4]) e.pa[i] = e.pd[j];
          if (d[j*4 +: 4] == b[i*4 +: 4]) e.pb[i] = e.pd[j];
        end
        if (h[i]) db++;
      end
    end
    expq.push_back(e);
    n = (rc < occ) ? rc : occ;
    for (int k = 0; k < n; k++) begin
      r = robq.pop_front();
      if (r.has) begin freev[rmap[r.arch]] = 1'b1; rmap[r.arch] = r.preg; end
      head_m = (head_m + 1) % RD;
    end
    if (e.rdy && nv > 0) begin
      for (int i = 0; i < W; i++) if (v[i]) begin
        if (h[i]) begin freev[e.pd[i]] = 1'b0; fmap[d[i*4 +: 4]] = e.pd[i]; end
        r.has = h[i]; r.arch = d[i*4 +: 4]; r.preg = e.pd[i];
        robq.push_back(r);
        tail_m = (tail_m + 1) % RD;
      end
    end
    if (fl) begin
      for (int p = 0; p < NP; p++) freev[p] = 1'b1;
      for (int q = 0; q < NA; q++) begin fmap[q] = rmap[q]; freev[rmap[q]] = 1'b0; end
      robq.delete();
      tail_m = head_m;
    end
  endtask

  // monitor: pops predictions mid-cycle and compares
  always @(negedge clk_i) begin
    if (expq.size() > 0) begin
      mon_e = expq.pop_front();
      check(mon_e.tag, "ready", int'(ren_ready_o), int'(mon_e.rdy));
      if (mon_e.rdy) begin
        for (int i = 0; i < W; i++) if (mon_e.v[i]) begin
          check(mon_e.tag, $sformatf("slot%0d rob_idx", i), int'(ren_rob_idx_o[i]), mon_e.ri[i]);
          check(mon_e.tag, $sformatf("slot%0d psrc_a", i), int'(ren_psrc_a_o[i]), mon_e.pa[i]);
          check(mon_e.tag, $sformatf("slot%0d psrc_b", i), int'(ren_psrc_b_o[i]), mon_e.pb[i]);
          if (mon_e.h[i])
            check(mon_e.tag, $sformatf("slot%0d pdst", i), int'(ren_pdst_o[i]), mon_e.pd[i]);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog all-reqs got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int q = 0; q < NA; q++) begin fmap[q] = q; rmap[q] = q; end
    for (int p = 0; p < NP; p++) freev[p] = (p >= NA);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset mapping and first allocation
    step("R1", 3'b111, 3'b111, pk(1,2,3), pk(4,5,6), pk(7,8,9), 0, 0);
    // R3 forwarding inside a group
    step("R3", 3'b111, 3'b011, pk(5,6,0), pk(5,5,6), pk(0,1,5), 0, 0);
    // R2 gap in the group, R4 duplicate destination
    step("R2", 3'b101, 3'b101, pk(7,0,7), pk(7,0,7), pk(1,0,2), 0, 0);
    step("R4", 3'b111, 3'b000, pk(0,0,0), pk(7,5,6), pk(1,2,3), 0, 0);
    // R6 retire frees previous committed mapping
    step("R6", 3'b000, 3'b000, pk(0,0,0), pk(0,0,0), pk(0,0,0), 3, 0);
    step("R6", 3'b111, 3'b111, pk(8,9,10), pk(1,2,3), pk(8,9,10), 0, 0);
    // R7 retiring without destination
    step("R7", 3'b000, 3'b000, pk(0,0,0), pk(0,0,0), pk(0,0,0), 3, 0);
    step("R7", 3'b111, 3'b111, pk(11,12,13), pk(5,6,7), pk(11,12,13), 0, 0);
    // R8 flush with same-cycle retire and ignored group
    step("R8", 3'b111, 3'b111, pk(1,2,3), pk(1,2,3), pk(1,2,3), 1, 1);
    step("R8", 3'b111, 3'b000, pk(0,0,0), pk(1,5,7), pk(8,2,6), 0, 0);
    step("R8", 3'b111, 3'b111, pk(14,15,0), pk(14,15,0), pk(7,7,7), 0, 0);
    step("R8", 3'b000, 3'b000, pk(0,0,0), pk(0,0,0), pk(0,0,0), 0, 1);
    // R5 free pool exhaustion, then reorder buffer exhaustion
    for (int g = 0; g < 10; g++)
      step("R5", 3'b111, 3'b111, pk(g%16,(g+5)%16,(g+9)%16), pk(g%16,1,2), pk(3,4,g%16), 0, 0);
    for (int g = 0; g < 4; g++)
      step("R5", 3'b111, 3'b000, pk(0,0,0), pk(g,1,2), pk(3,4,5), 0, 0);
    step("R5", 3'b001, 3'b000, pk(0,0,0), pk(6,0,0), pk(7,0,0), 0, 0);
    step("R5", 3'b011, 3'b000, pk(0,0,0), pk(6,7,0), pk(7,8,0), 0, 0);
    // R6 retire request beyond occupancy is clamped
    step("R6", 3'b000, 3'b000, pk(0,0,0), pk(0,0,0), pk(0,0,0), 0, 1);
    step("R6", 3'b000, 3'b000, pk(0,0,0), pk(0,0,0), pk(0,0,0), 3, 0);
    step("R6", 3'b111, 3'b111, pk(2,4,6), pk(2,4,6), pk(1,3,5), 0, 0);

    // mixed traffic covering R2 R3 R4 R5 R6 R7 R8
    for (int t = 0; t < 3000; t++)
      step("R2 R3 R4 R5 R6 R7 R8", 3'($urandom), 3'($urandom), 12'($urandom),
           12'($urandom), 12'($urandom), int'($urandom % 4), ($urandom % 40) == 0);

    step("R5", 3'b000, 3'b000, pk(0,0,0), pk(0,0,0), pk(0,0,0), 0, 0);
    @(posedge clk_i); @(posedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule